// File: doc/BRIEF.md
# EEPROM Burst Register Loader

This block reads the content of a configuration EEPROM one byte at a time and turns it into 32-bit register writes. It fetches bytes over a request/response port. `rd_req` stays high with a stable `rd_addr` until the memory side answers with a one-cycle `rd_valid` and the byte on `rd_data`. The stream begins with a validity flag and a burst count. Each burst then has a two-byte header, a DWORD address and a DWORD count, followed by that many DWORDs of data. Each DWORD is sent out on a register write port with a 10-bit byte address.

Register writes are held back while either of two external interfaces reports busy. The EEPROM byte address is checked against an upper bound chosen by a two-bit size strap. When the next read would go past that bound, the load stops and a sticky overflow flag is raised. A one-cycle `start` pulse begins a load, or restarts one that is already running.

The controller has seven states:
- `ST_IDLE` waits for `start`.
- `ST_FLAG`, `ST_NBURST`, `ST_HADDR`, `ST_HCNT` and `ST_DATA` each read one kind of byte.
- `ST_WRITE` holds an assembled DWORD until it has been written.

The transitions are:
- IDLE→FLAG on start. Any state goes to FLAG on start.
- FLAG→NBURST when the flag is A5h. FLAG→IDLE otherwise.
- NBURST→HADDR when the count is non-zero. NBURST→IDLE when it is zero.
- HADDR→HCNT.
- HCNT→DATA when the DWORD count is non-zero. HCNT→HADDR or HCNT→IDLE when it is zero.
- DATA→WRITE on the fourth byte.
- WRITE→DATA when DWORDs remain in the burst. WRITE→HADDR at the end of a burst. WRITE→IDLE after the last burst.
- Any read state goes to IDLE on an address overflow.

Top module: `eeprom_burst_loader`

## Requirements
- R1: After `start`, the first byte read is at EEPROM byte address 1. Only when that byte equals A5h does parsing continue. For any other value the block makes no write, returns to idle with `done`=1, and leaves `overflow`=0.
- R2: The byte after the flag gives the number of bursts N. Exactly N header-and-data groups are parsed. N=0 produces no write.
- R3: Each burst header is an address byte A followed by a count byte C. The burst writes C DWORDs to byte addresses {A,2'b00}, {A+1,2'b00}, and so on. The 8-bit DWORD address wraps from FFh to 00h. C=0 produces no write, and the next header follows at once.
- R4: Each DWORD is built from four consecutive bytes, the first byte becoming bits 31:24 and the last bits 7:0.
- R5: `wr_en` is never high while `csr_busy` or `pmi_busy` is high. A completed DWORD waits, unchanged, until both are low. Each DWORD is written exactly once.
- R6: `rd_req` stays high with `rd_addr` stable until `rd_valid` is seen. Successive accepted reads use consecutive byte addresses.
- R7: The EEPROM byte address limit is 2^(7+3·`size_sel`)−1, which gives 127, 1023, 8191 or 65535. No read is issued above the limit. When the next read would pass it, loading stops, `overflow` is set and stays set until the next `start`, and `busy` falls.
- R8: `busy` is high from the cycle after `start` until the load ends. `done` is cleared by `start` and set when a load ends. `busy` and `done` are never both high.
- R9: A `start` during a load abandons it, drops any unwritten DWORD, and begins again at byte 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins or restarts a load |
| size_sel | input | 2 | Size strap that selects the address limit |
| rd_req | output | 1 | EEPROM byte read request |
| rd_addr | output | EAW | EEPROM byte address of the request |
| rd_valid | input | 1 | One-cycle answer to the pending request |
| rd_data | input | 8 | Byte returned with `rd_valid` |
| csr_busy | input | 1 | First interface busy; blocks writes |
| pmi_busy | input | 1 | Second interface busy; blocks writes |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 10 | Register byte address |
| wr_data | output | 32 | Register write data |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load finished (sticky until `start`) |
| overflow | output | 1 | Address limit reached (sticky until `start`) |

## Verification
The bench attacks the following corner cases, each of which exposes a specific fault:
- **Header with a count of zero.** A design that decrements before testing would write 256 DWORDs.
- **DWORD address wrap from FFh.** A design that carries into a ninth bit would write outside the 10-bit space.
- **Bad flag byte.** A design that ignores the flag would emit writes.
- **Zero bursts.**
- **Overflow part-way through a DWORD under the smallest strap.** A wrong limit, or an off-by-one compare, changes how many writes precede the stop.

Random streams are read back with random memory latency and random busy patterns. A gate that releases a write while a busy input is high, or that drops or repeats a write, shows up as a wrong write list. A restart in the middle of a load must yield the full write list of a fresh run, with no stale DWORD.

// File: rtl/eebl_pkg.sv
package eebl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLAG,
        ST_NBURST,
        ST_HADDR,
        ST_HCNT,
        ST_DATA,
        ST_WRITE
    } eebl_state_e;

    localparam logic [7:0] FLAG_VALID = 8'hA5;
endpackage

// File: rtl/eebl_byte_fetch.sv
module eebl_byte_fetch #(
    parameter int EAW     = 16,
    parameter int MIN_LOG = 7,
    parameter int STEP    = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           want,
    input  logic [1:0]     size_sel,
    input  logic           rd_valid,
    output logic           rd_req,
    output logic [EAW-1:0] rd_addr,
    output logic           got,
    output logic           beyond
);
    localparam int CW = EAW + 1;

    logic [CW-1:0] addr_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit  = (CW'(1) << (MIN_LOG + STEP * int'(size_sel))) - CW'(1);
        beyond = addr_q > limit;
        rd_req = want && !beyond;
        got    = rd_req && rd_valid;
    end

    assign rd_addr = addr_q[EAW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= CW'(1);
        end else if (restart) begin
            addr_q <= CW'(1);
        end else if (got) begin
            addr_q <= addr_q + CW'(1);
        end
    end

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_valid && !restart |=> rd_req && $stable(rd_addr));
endmodule

// File: rtl/eebl_dword_asm.sv
module eebl_dword_asm #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [7:0]    byte_in,
    output logic [DW-1:0] next_word,
    output logic          last
);
    localparam int NB = DW / 8;
    localparam int IW = (NB > 1) ? $clog2(NB) : 1;

    logic [DW-1:0] word_q;
    logic [IW-1:0] idx_q;

    assign next_word = {word_q[DW-9:0], byte_in};
    assign last      = (idx_q == IW'(NB - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (clear) begin
            word_q <= '0;
            idx_q  <= '0;
        end else if (push) begin
            word_q <= next_word;
            idx_q  <= last ? '0 : idx_q + IW'(1);
        end
    end
endmodule

// File: rtl/eebl_write_gate.sv
module eebl_write_gate #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          launch,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    input  logic          csr_busy,
    input  logic          pmi_busy,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    logic pend_q;

    assign wr_en = pend_q && !csr_busy && !pmi_busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else if (flush) begin
            pend_q <= 1'b0;
        end else if (launch) begin
            pend_q  <= 1'b1;
            wr_addr <= addr_in;
            wr_data <= data_in;
        end else if (wr_en) begin
            pend_q <= 1'b0;
        end
    end

    // R5
    wr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q && (csr_busy || pmi_busy) && !flush |=> pend_q && $stable(wr_data) && $stable(wr_addr));
endmodule

// File: rtl/eeprom_burst_loader.sv
module eeprom_burst_loader
    import eebl_pkg::*;
#(
    parameter int EAW     = 16,
    parameter int MIN_LOG = 7,
    parameter int STEP    = 3,
    parameter int HDR_W   = 8,
    parameter int DW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         size_sel,
    output logic               rd_req,
    output logic [EAW-1:0]     rd_addr,
    input  logic               rd_valid,
    input  logic [7:0]         rd_data,
    input  logic               csr_busy,
    input  logic               pmi_busy,
    output logic               wr_en,
    output logic [HDR_W+1:0]   wr_addr,
    output logic [DW-1:0]      wr_data,
    output logic               busy,
    output logic               done,
    output logic               overflow
);
    localparam int RAW = HDR_W + 2;

    eebl_state_e state_q, state_d;

    logic [7:0]       nb_q;
    logic [7:0]       cnt_q;
    logic [HDR_W-1:0] dwa_q;
    logic             done_q, ovf_q;

    logic             want, got, beyond;
    logic             push, launch, word_last;
    logic [DW-1:0]    next_word;
    logic             read_st, last_burst, end_run, ovf_hit;

    eebl_byte_fetch #(.EAW(EAW), .MIN_LOG(MIN_LOG), .STEP(STEP)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (start),
        .want     (want),
        .size_sel (size_sel),
        .rd_valid (rd_valid),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .got      (got),
        .beyond   (beyond)
    );

    eebl_dword_asm #(.DW(DW)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .push      (push),
        .byte_in   (rd_data),
        .next_word (next_word),
        .last      (word_last)
    );

    eebl_write_gate #(.AW(RAW), .DW(DW)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (start),
        .launch   (launch),
        .addr_in  ({dwa_q, 2'b00}),
        .data_in  (next_word),
        .csr_busy (csr_busy),
        .pmi_busy (pmi_busy),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    assign read_st    = (state_q == ST_FLAG) || (state_q == ST_NBURST) ||
                        (state_q == ST_HADDR) || (state_q == ST_HCNT) ||
                        (state_q == ST_DATA);
    assign last_burst = (nb_q == 8'd1);

    // next state
    always_comb begin
        state_d = state_q;
        ovf_hit = 1'b0;
        if (start) begin
            state_d = ST_FLAG;
        end else if (read_st && beyond) begin
            state_d = ST_IDLE;
            ovf_hit = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_FLAG:   if (got) state_d = (rd_data == FLAG_VALID) ? ST_NBURST : ST_IDLE;
                ST_NBURST: if (got) state_d = (rd_data == 8'd0) ? ST_IDLE : ST_HADDR;
                ST_HADDR:  if (got) state_d = ST_HCNT;
                ST_HCNT:   if (got) state_d = (rd_data != 8'd0) ? ST_DATA
                                            : (last_burst ? ST_IDLE : ST_HADDR);
                ST_DATA:   if (got && word_last) state_d = ST_WRITE;
                ST_WRITE:  if (wr_en) state_d = (cnt_q != 8'd1) ? ST_DATA
                                               : (last_burst ? ST_IDLE : ST_HADDR);
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        want    = read_st;
        push    = (state_q == ST_DATA) && got;
        launch  = push && word_last && !start;
        end_run = !start && (state_q != ST_IDLE) && (state_d == ST_IDLE);
        busy    = (state_q != ST_IDLE);
        done    = done_q;
        overflow = ovf_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nb_q  <= '0;
            cnt_q <= '0;
            dwa_q <= '0;
        end else if (start) begin
            nb_q  <= '0;
            cnt_q <= '0;
            dwa_q <= '0;
        end else begin
            if (state_q == ST_NBURST && got) nb_q <= rd_data;
            if (state_q == ST_HADDR && got)  dwa_q <= rd_data[HDR_W-1:0];
            if (state_q == ST_HCNT && got) begin
                cnt_q <= rd_data;
                if (rd_data == 8'd0) nb_q <= nb_q - 8'd1;
            end
            if (state_q == ST_WRITE && wr_en) begin
                dwa_q <= dwa_q + HDR_W'(1);
                cnt_q <= cnt_q - 8'd1;
                if (cnt_q == 8'd1) nb_q <= nb_q - 8'd1;
            end
        end
    end

    // status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (start) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (end_run) done_q <= 1'b1;
            if (ovf_hit) ovf_q  <= 1'b1;
        end
    end

    // R8
    busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R7
    ovf_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> !busy && done);

    // R5
    wr_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy && !csr_busy && !pmi_busy);

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && !done && !overflow);
endmodule

// File: tb/eeprom_burst_loader_tb.sv
module eeprom_burst_loader_tb;
    localparam int EAW   = 16;
    localparam int MEMSZ = 4096;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      size_sel = 2'd1;
    logic            rd_req;
    logic [EAW-1:0]  rd_addr;
    logic            rd_valid = 1'b0;
    logic [7:0]      rd_data = 8'h00;
    logic            csr_busy = 1'b0;
    logic            pmi_busy = 1'b0;
    logic            wr_en;
    logic [9:0]      wr_addr;
    logic [31:0]     wr_data;
    logic            busy, done, overflow;

    eeprom_burst_loader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .csr_busy(csr_busy), .pmi_busy(pmi_busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .overflow(overflow)
    );

    always #10 clk = ~clk;

    logic [7:0]  mem [0:MEMSZ-1];
    int          n_chk = 0, n_bad = 0, cycles = 0;
    int          max_lat = 0, busy_pct = 0;
    int          cur_lim;
    logic [9:0]  exp_a[$], act_a[$];
    logic [31:0] exp_d[$], act_d[$];
    bit          exp_ovf;
    int          seq_err = 0, gate_err = 0, wp;
    bit          have_prev = 0;
    logic [EAW-1:0] prev_addr;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic logic [7:0] memrd(input int a);
        return (a < MEMSZ) ? mem[a] : 8'hFF;
    endfunction

    function automatic int rdb(input int p);
        if (p > cur_lim) return -1;
        return int'(memrd(p));
    endfunction

    // reference parse built from R1-style rules: flag, count, headers, data
    task automatic compute_expected();
        int p, b, nb, a, c, x;
        logic [31:0] w;
        exp_a.delete(); exp_d.delete(); exp_ovf = 0; p = 1;
        b = rdb(p); p++;
        if (b < 0) begin exp_ovf = 1; return; end
        if (b != 8'hA5) return;
        nb = rdb(p); p++;
        if (nb < 0) begin exp_ovf = 1; return; end
        for (int bi = 0; bi < nb; bi++) begin
            a = rdb(p); p++;
            if (a < 0) begin exp_ovf = 1; return; end
            c = rdb(p); p++;
            if (c < 0) begin exp_ovf = 1; return; end
            for (int k = 0; k < c; k++) begin
                w = '0;
                for (int j = 0; j < 4; j++) begin
                    x = rdb(p); p++;
                    if (x < 0) begin exp_ovf = 1; return; end
                    w = {w[23:0], 8'(x)};
                end
                exp_a.push_back({8'(a), 2'b00});
                exp_d.push_back(w);
                a = (a + 1) & 255;
            end
        end
    endtask

    task automatic mem_clear();
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'hFF;
        mem[0] = 8'h5A;
        wp = 1;
    endtask

    task automatic put(input logic [7:0] b);
        if (wp < MEMSZ) mem[wp] = b;
        wp++;
    endtask

    task automatic tick();
        @(negedge clk); #5;
    endtask

    // memory responder
    initial begin : mem_model
        int lat;
        lat = 0;
        forever begin
            @(negedge clk);
            if (rd_valid) rd_valid = 1'b0;
            else if (rd_req) begin
                if (lat == 0) begin
                    rd_valid = 1'b1;
                    rd_data  = memrd(int'(rd_addr));
                    lat = $urandom_range(0, max_lat);
                end else lat--;
            end
        end
    end

    // busy driver
    initial begin
        forever begin
            @(negedge clk);
            csr_busy = ($urandom_range(0, 99) < busy_pct);
            pmi_busy = ($urandom_range(0, 99) < busy_pct);
        end
    end

    // monitor
    initial begin
        forever begin
            tick();
            cycles++;
            if (wr_en) begin
                act_a.push_back(wr_addr);
                act_d.push_back(wr_data);
                if (csr_busy || pmi_busy) gate_err++;
            end
            if (rd_req && rd_valid) begin
                if (have_prev && rd_addr != prev_addr + 1'b1) seq_err++;
                if (!have_prev && rd_addr != 1) seq_err++;
                prev_addr = rd_addr;
                have_prev = 1;
            end
        end
    end

    // watchdog
    initial begin
        wait (cycles > 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
        summary();
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(posedge clk); #1;
        act_a.delete(); act_d.delete(); have_prev = 0; seq_err = 0; gate_err = 0;
        @(negedge clk); start = 1'b0;
        #5;
    endtask

    task automatic wait_end(input string name);
        int n;
        n = 0;
        while (busy && n < 20000) begin tick(); n++; end
        chk(!busy, "R8", {name, " load ends"}, busy, 0);
    endtask

    task automatic run_case(input string name, input logic [1:0] sel);
        size_sel = sel;
        cur_lim  = (1 << (7 + 3 * int'(sel))) - 1;
        compute_expected();
        pulse_start();
        // R8 R6: busy at once, first read at byte 1
        chk(busy && !done && !overflow, "R8", {name, " busy after start"},
            {busy, done, overflow}, 3'b100);
        chk(rd_req && rd_addr == 1, "R6", {name, " first read address"}, rd_addr, 1);
        wait_end(name);
        chk(done, "R8", {name, " done"}, done, 1);
        chk(overflow == exp_ovf, "R7", {name, " overflow"}, overflow, exp_ovf);
        chk(act_a.size() == exp_a.size(), "R2", {name, " write count"},
            act_a.size(), exp_a.size());
        for (int i = 0; i < exp_a.size() && i < act_a.size(); i++) begin
            chk(act_a[i] == exp_a[i], "R3", {name, " write address"}, act_a[i], exp_a[i]);
            chk(act_d[i] == exp_d[i], "R4", {name, " write data"}, act_d[i], exp_d[i]);
        end
        chk(gate_err == 0, "R5", {name, " write while busy"}, gate_err, 0);
        chk(seq_err == 0, "R6", {name, " read sequence"}, seq_err, 0);
    endtask

    task automatic build_random();
        int nb, c;
        mem_clear();
        if ($urandom_range(0, 9) == 0) put(8'($urandom_range(0, 164)));
        else put(8'hA5);
        nb = $urandom_range(0, 4);
        put(8'(nb));
        for (int b = 0; b < nb; b++) begin
            put(8'($urandom));
            c = $urandom_range(0, 6);
            put(8'(c));
            for (int k = 0; k < 4 * c; k++) put(8'($urandom));
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        mem_clear();
        repeat (3) @(negedge clk);
        #5;
        chk(!busy && !done && !overflow && !wr_en && !rd_req, "R8", "reset state",
            {busy, done, overflow, wr_en, rd_req}, 0);
        rst_n = 1'b1;
        repeat (2) tick();

        // three bursts, directed (R2 R3 R4)
        mem_clear();
        put(8'hA5); put(8'd3);
        put(8'h10); put(8'd1); put(8'hDE); put(8'hAD); put(8'hBE); put(8'hEF);
        put(8'h20); put(8'd2); for (int i = 0; i < 8; i++) put(8'(8'h40 + i));
        put(8'h30); put(8'd3); for (int i = 0; i < 12; i++) put(8'(8'h90 + i));
        run_case("three_bursts", 2'd1);
        chk(act_a.size() > 0 && act_a[0] == 10'h040, "R3", "header 10h maps to 40h",
            act_a.size() > 0 ? act_a[0] : 0, 10'h040);
        chk(act_d.size() > 0 && act_d[0] == 32'hDEADBEEF, "R4", "byte order",
            act_d.size() > 0 ? act_d[0] : 0, 32'hDEADBEEF);

        // R1: bad flag
        mem_clear(); put(8'hA4); put(8'd2); put(8'h01); put(8'd1);
        run_case("bad_flag", 2'd1);
        chk(act_a.size() == 0, "R1", "no write on bad flag", act_a.size(), 0);

        // R2: zero bursts
        mem_clear(); put(8'hA5); put(8'd0);
        run_case("zero_bursts", 2'd2);

        // R3: zero count then wrap
        mem_clear(); put(8'hA5); put(8'd2);
        put(8'h33); put(8'd0);
        put(8'hFE); put(8'd3); for (int i = 0; i < 12; i++) put(8'(i * 17));
        run_case("zero_count_wrap", 2'd3);
        chk(act_a.size() == 3 && act_a[2] == 10'h000, "R3", "address wrap",
            act_a.size() == 3 ? act_a[2] : 10'h3FF, 10'h000);

        // R7: overflow mid-dword under smallest strap, with busy traffic
        busy_pct = 40; max_lat = 2;
        mem_clear(); put(8'hA5); put(8'd1); put(8'h40); put(8'd40);
        for (int i = 0; i < 160; i++) put(8'($urandom));
        run_case("overflow_small", 2'd0);
        chk(overflow && act_a.size() == 30, "R7", "writes before overflow", act_a.size(), 30);

        // R7: overflow flag clears on next start
        mem_clear(); put(8'hA5); put(8'd1); put(8'h02); put(8'd1);
        put(8'h01); put(8'h02); put(8'h03); put(8'h04);
        run_case("ovf_clear", 2'd0);
        chk(!overflow, "R7", "overflow cleared by start", overflow, 0);

        // R9: restart in the middle of a load
        mem_clear(); put(8'hA5); put(8'd2);
        put(8'h80); put(8'd5); for (int i = 0; i < 20; i++) put(8'($urandom));
        put(8'h08); put(8'd4); for (int i = 0; i < 16; i++) put(8'($urandom));
        size_sel = 2'd1;
        pulse_start();
        repeat (40) tick();
        run_case("restart", 2'd1);
        chk(act_a.size() == 9, "R9", "full list after restart", act_a.size(), 9);

        // random streams
        for (int t = 0; t < 24; t++) begin
            build_random();
            busy_pct = $urandom_range(0, 60);
            max_lat  = $urandom_range(0, 3);
            run_case("random", 2'($urandom_range(0, 3)));
        end

        repeat (4) tick();
        summary();
    end
endmodule